// File: doc/BRIEF.md
# Exclusive Access Reservation Monitor

This block keeps the reservations behind load-exclusive / store-exclusive pairs for a small group of cores. Each core owns one reservation. The reservation is a tag naming a 64-byte aligned granule, plus two flags. The local flag can be dropped only by events on the owning core. The global flag is dropped when another core writes into the reserved granule. A store-exclusive is allowed to write only when both flags are still set and its address falls in the reserved granule. One cycle after the request the block returns a pass/fail status and a write-enable grant for that core.

Each core drives one request strobe per cycle, with an operation code and a byte address. Each core also has a separate exception-return strobe. A core's reservation is held in a four-state machine, where each state stands for one combination of the two flags:

- Idle: no reservation.
- Armed: both flags set.
- LocalOnly: the global flag was lost to another core's write.
- GlobalOnly: the local flag was lost to an exception return.

The transitions are:

- load (a load-exclusive from any state) moves to Armed.
- snoop (Armed to LocalOnly, or GlobalOnly to Idle): another core writes into the reserved granule.
- return (Armed to GlobalOnly, or LocalOnly to Idle): the core takes an exception return.
- both (Armed to Idle): snoop and return in the same cycle.
- drop (any state to Idle): a store-exclusive or a clear request.

Top module: `excl_monitor`

## Requirements
- R1: After reset every core is Idle, all outputs are 0, and a first store-exclusive from any core fails.
- R2: Operation codes are 00 plain store, 01 load-exclusive, 10 store-exclusive and 11 clear, each valid only while the core's request strobe is high. A load-exclusive followed by a store-exclusive to any byte of the same 64-byte granule (address bits above bit 5 equal) passes: status fail=0 and write grant=1.
- R3: A store-exclusive to a granule other than the reserved one fails and gets no write grant.
- R4: Every store-exclusive, whether it passes or fails, leaves its core Idle, so a second store-exclusive fails.
- R5: A new load-exclusive replaces the earlier reservation. A store-exclusive to the old granule then fails, and one to the new granule passes.
- R6: A plain store or a granted store-exclusive by another core into the reserved granule drops the global flag. A store by another core to a different granule, and a plain store by the owning core itself, leave the reservation intact.
- R7: An exception return on a core drops only that core's local flag. Other cores' reservations are unaffected.
- R8: A clear request returns the requesting core to Idle without any write grant.
- R9: When several store-exclusives to one granule arrive in the same cycle, only the lowest-index eligible core is granted. The others fail, and the granted write also drops the global flag of every other core reserved on that granule.
- R10: Status valid is a one-cycle pulse in the cycle after a store-exclusive request, and is never raised without one. A write grant is raised only together with a passing status.
- R11: Precedence within a cycle: a core's own load-exclusive overrides a same-cycle exception return or foreign write, leaving it Armed. A store-exclusive fails if the same cycle brings its own exception return or another core's plain store to that granule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld_i | input | NUM_CORES | Per-core request strobe |
| req_op_i | input | 2*NUM_CORES | Per-core operation code, core c at bits [2c+1:2c] |
| req_addr_i | input | ADDR_W*NUM_CORES | Per-core byte address, core c at bits [ADDR_W*c +: ADDR_W] |
| eret_i | input | NUM_CORES | Per-core exception-return event |
| sx_vld_o | output | NUM_CORES | Store-exclusive status valid |
| sx_fail_o | output | NUM_CORES | Store-exclusive status, 1 = failed |
| wr_en_o | output | NUM_CORES | Write-enable grant for the store-exclusive |

## Verification
The hardest situation to reach is a collision inside one cycle. Several store-exclusives race for one granule, or a core's own operation meets a foreign write or an exception return on the same edge. Whether the outcome is right depends on precedence and on the index order of the cores. The bench drives every core's request lines independently within a single cycle. It sweeps every ordered pair of cores and every starting index of the contending group, so each collision shape is exercised. Expected pass and fail values follow from the core indices alone.

// File: rtl/excl_mon_pkg.sv
package excl_mon_pkg;

    typedef enum logic [1:0] {
        OP_STORE = 2'b00,
        OP_LDX   = 2'b01,
        OP_STX   = 2'b10,
        OP_CLR   = 2'b11
    } mon_op_e;

    typedef enum logic [1:0] {
        MS_IDLE        = 2'b00,
        MS_ARMED       = 2'b01,
        MS_LOCAL_ONLY  = 2'b10,
        MS_GLOBAL_ONLY = 2'b11
    } mon_state_e;

endpackage

// File: rtl/excl_mon_core.sv
module excl_mon_core
    import excl_mon_pkg::*;
#(
    parameter int TAG_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ldx_i,
    input  logic             stx_i,
    input  logic             clr_i,
    input  logic             eret_i,
    input  logic [TAG_W-1:0] req_tag_i,
    input  logic             snoop_hit_i,
    input  logic             grant_i,
    output logic             stx_ok_o,
    output logic [TAG_W-1:0] res_tag_o,
    output logic             sx_vld_o,
    output logic             sx_fail_o,
    output logic             wr_en_o
);

    mon_state_e       state_q, state_d;
    logic [TAG_W-1:0] tag_q;

    // next-state: decay from events first, then own operation overrides
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MS_IDLE:        state_d = MS_IDLE;
            MS_ARMED: begin
                if (eret_i && snoop_hit_i) state_d = MS_IDLE;
                else if (eret_i)           state_d = MS_GLOBAL_ONLY;
                else if (snoop_hit_i)      state_d = MS_LOCAL_ONLY;
            end
            MS_LOCAL_ONLY:  if (eret_i)      state_d = MS_IDLE;
            MS_GLOBAL_ONLY: if (snoop_hit_i) state_d = MS_IDLE;
            default:        state_d = MS_IDLE;
        endcase
        if (ldx_i)               state_d = MS_ARMED;
        else if (stx_i || clr_i) state_d = MS_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= MS_IDLE;
            tag_q   <= '0;
        end else begin
            state_q <= state_d;
            if (ldx_i) tag_q <= req_tag_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sx_vld_o  <= 1'b0;
            sx_fail_o <= 1'b0;
            wr_en_o   <= 1'b0;
        end else begin
            sx_vld_o  <= stx_i;
            sx_fail_o <= stx_i && !grant_i;
            wr_en_o   <= stx_i && grant_i;
        end
    end

    assign stx_ok_o  = stx_i && !eret_i && (state_q == MS_ARMED) && (tag_q == req_tag_i);
    assign res_tag_o = tag_q;

    AST_LDX_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        ldx_i |=> (state_q == MS_ARMED) && (tag_q == $past(req_tag_i))); // R2
    AST_STX_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (stx_i && !ldx_i) |=> (state_q == MS_IDLE)); // R4
    AST_CLR_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !ldx_i) |=> (state_q == MS_IDLE) && !wr_en_o); // R8
    AST_ERET_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
        (eret_i && !ldx_i) |=> !(state_q inside {MS_ARMED, MS_LOCAL_ONLY})); // R7
    AST_SNOOP_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
        (snoop_hit_i && !ldx_i) |=> !(state_q inside {MS_ARMED, MS_GLOBAL_ONLY})); // R6
    AST_STATUS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !stx_i |=> !sx_vld_o); // R10
    AST_WR_ONLY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> (sx_vld_o && !sx_fail_o)); // R10

endmodule

// File: rtl/excl_mon_arb.sv
module excl_mon_arb #(
    parameter int NUM_CORES = 4,
    parameter int TAG_W     = 10
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_CORES-1:0]             stx_ok_i,
    input  logic [NUM_CORES-1:0]             st_req_i,
    input  logic [NUM_CORES-1:0][TAG_W-1:0] req_tag_i,
    input  logic [NUM_CORES-1:0][TAG_W-1:0] res_tag_i,
    output logic [NUM_CORES-1:0]             grant_o,
    output logic [NUM_CORES-1:0]             snoop_hit_o
);

    logic [NUM_CORES-1:0] wr_any;

    // fixed priority: lowest index wins; a foreign plain store blocks too
    always_comb begin
        for (int i = 0; i < NUM_CORES; i++) begin
            grant_o[i] = stx_ok_i[i];
            for (int j = 0; j < NUM_CORES; j++) begin
                if (j != i && st_req_i[j] && req_tag_i[j] == req_tag_i[i])
                    grant_o[i] = 1'b0;
                if (j < i && stx_ok_i[j] && req_tag_i[j] == req_tag_i[i])
                    grant_o[i] = 1'b0;
            end
        end
    end

    assign wr_any = st_req_i | grant_o;

    always_comb begin
        for (int i = 0; i < NUM_CORES; i++) begin
            snoop_hit_o[i] = 1'b0;
            for (int j = 0; j < NUM_CORES; j++)
                if (j != i && wr_any[j] && req_tag_i[j] == res_tag_i[i])
                    snoop_hit_o[i] = 1'b1;
        end
    end

    for (genvar a = 0; a < NUM_CORES; a++) begin : g_pa
        for (genvar b = a + 1; b < NUM_CORES; b++) begin : g_pb
            AST_SINGLE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
                !(grant_o[a] && grant_o[b] && req_tag_i[a] == req_tag_i[b])); // R9
        end
    end

endmodule

// File: rtl/excl_monitor.sv
module excl_monitor
    import excl_mon_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int ADDR_W    = 16,
    parameter int GRAN_BITS = 6
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_CORES-1:0]        req_vld_i,
    input  logic [2*NUM_CORES-1:0]      req_op_i,
    input  logic [ADDR_W*NUM_CORES-1:0] req_addr_i,
    input  logic [NUM_CORES-1:0]        eret_i,
    output logic [NUM_CORES-1:0]        sx_vld_o,
    output logic [NUM_CORES-1:0]        sx_fail_o,
    output logic [NUM_CORES-1:0]        wr_en_o
);

    localparam int TAG_W = ADDR_W - GRAN_BITS;

    logic [NUM_CORES-1:0]             ldx, stx, clr, st_req, stx_ok, grant, snoop_hit;
    logic [NUM_CORES-1:0][TAG_W-1:0] req_tag, res_tag;
    logic [NUM_CORES-1:0][GRAN_BITS-1:0] low_bits;
    logic unused_low;

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        mon_op_e op;
        assign op          = mon_op_e'(req_op_i[2*c +: 2]);
        assign ldx[c]      = req_vld_i[c] && (op == OP_LDX);
        assign stx[c]      = req_vld_i[c] && (op == OP_STX);
        assign clr[c]      = req_vld_i[c] && (op == OP_CLR);
        assign st_req[c]   = req_vld_i[c] && (op == OP_STORE);
        assign req_tag[c]  = req_addr_i[ADDR_W*c + GRAN_BITS +: TAG_W];
        assign low_bits[c] = req_addr_i[ADDR_W*c +: GRAN_BITS];

        excl_mon_core #(.TAG_W(TAG_W)) u_core (
            .clk         (clk),
            .rst_n       (rst_n),
            .ldx_i       (ldx[c]),
            .stx_i       (stx[c]),
            .clr_i       (clr[c]),
            .eret_i      (eret_i[c]),
            .req_tag_i   (req_tag[c]),
            .snoop_hit_i (snoop_hit[c]),
            .grant_i     (grant[c]),
            .stx_ok_o    (stx_ok[c]),
            .res_tag_o   (res_tag[c]),
            .sx_vld_o    (sx_vld_o[c]),
            .sx_fail_o   (sx_fail_o[c]),
            .wr_en_o     (wr_en_o[c])
        );
    end

    assign unused_low = ^low_bits;

    excl_mon_arb #(.NUM_CORES(NUM_CORES), .TAG_W(TAG_W)) u_arb (
        .clk         (clk),
        .rst_n       (rst_n),
        .stx_ok_i    (stx_ok),
        .st_req_i    (st_req),
        .req_tag_i   (req_tag),
        .res_tag_i   (res_tag),
        .grant_o     (grant),
        .snoop_hit_o (snoop_hit)
    );

    AST_GRANT_ONEHOT_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o & ~sx_vld_o) == '0); // R10

endmodule

// File: tb/excl_monitor_bench.sv
`timescale 1ns/1ps
module excl_monitor_bench;

    localparam int N  = 4;
    localparam int AW = 16;

    localparam logic [1:0] C_ST  = 2'b00;
    localparam logic [1:0] C_LDX = 2'b01;
    localparam logic [1:0] C_STX = 2'b10;
    localparam logic [1:0] C_CLR = 2'b11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0]    vld = '0, eret = '0;
    logic [1:0]      op [N];
    logic [AW-1:0]   addr [N];
    logic [2*N-1:0]  op_flat;
    logic [AW*N-1:0] addr_flat;
    logic [N-1:0]    sx_vld, sx_fail, wr_en;
    int tests = 0, fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    always_comb begin
        for (int c = 0; c < N; c++) begin
            op_flat[2*c +: 2]    = op[c];
            addr_flat[AW*c +: AW] = addr[c];
        end
    end

    excl_monitor #(.NUM_CORES(N), .ADDR_W(AW), .GRAN_BITS(6)) u_excl_monitor (
        .clk(clk), .rst_n(rst_n), .req_vld_i(vld), .req_op_i(op_flat),
        .req_addr_i(addr_flat), .eret_i(eret),
        .sx_vld_o(sx_vld), .sx_fail_o(sx_fail), .wr_en_o(wr_en)
    );

    function automatic logic [AW-1:0] ga(int g, int off);
        return AW'((g << 6) | (off & 63));
    endfunction

    task automatic put(int c, logic [1:0] o, logic [AW-1:0] a);
        vld[c] = 1'b1; op[c] = o; addr[c] = a;
    endtask

    task automatic idle_all();
        for (int c = 0; c < N; c++) begin
            vld[c] = 1'b0; op[c] = C_ST; addr[c] = '0; eret[c] = 1'b0;
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string rq, int c, bit ev, bit ef, bit ew);
        tests++;
        if (sx_vld[c] !== ev || sx_fail[c] !== ef || wr_en[c] !== ew) begin
            fails++;
            $display("FAIL %s core%0d: vld/fail/wr actual %b%b%b expected %b%b%b",
                     rq, c, sx_vld[c], sx_fail[c], wr_en[c], ev, ef, ew);
        end
    endtask

    task automatic ldx(int c, logic [AW-1:0] a);
        put(c, C_LDX, a); step(); idle_all();
    endtask

    task automatic stx_chk(string rq, int c, logic [AW-1:0] a, bit pass);
        put(c, C_STX, a); step(); chk(rq, c, 1'b1, !pass, pass); idle_all();
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog: run did not complete");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        idle_all();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        for (int c = 0; c < N; c++) chk("R1", c, 0, 0, 0);
        for (int c = 0; c < N; c++) stx_chk("R1", c, ga(c, 0), 1'b0);
        // R2 any offset within granule passes
        for (int c = 0; c < N; c++)
            for (int k = 0; k < 4; k++) begin
                ldx(c, ga(3*c+1, 5));
                stx_chk("R2", c, ga(3*c+1, (k*21) % 64), 1'b1);
            end
        // R3 other granule fails; R4 second store-exclusive fails
        for (int c = 0; c < N; c++) begin
            ldx(c, ga(7, 0));
            stx_chk("R3", c, ga(8, 0), 1'b0);
            stx_chk("R4", c, ga(7, 0), 1'b0);
            ldx(c, ga(7, 0));
            stx_chk("R4", c, ga(7, 9), 1'b1);
            stx_chk("R4", c, ga(7, 9), 1'b0);
        end
        // R5 replacement
        for (int c = 0; c < N; c++) begin
            ldx(c, ga(30, 0)); ldx(c, ga(31, 0));
            stx_chk("R5", c, ga(30, 0), 1'b0);
            ldx(c, ga(30, 0)); ldx(c, ga(31, 0));
            stx_chk("R5", c, ga(31, 0), 1'b1);
        end
        // R6 foreign stores, own store
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++) if (i != j) begin
                ldx(i, ga(40, 0));
                put(j, C_ST, ga(40, 33)); step(); idle_all();
                stx_chk("R6", i, ga(40, 0), 1'b0);
                ldx(i, ga(40, 0));
                put(j, C_ST, ga(41, 0)); step(); idle_all();
                stx_chk("R6", i, ga(40, 0), 1'b1);
                ldx(i, ga(40, 0));
                put(i, C_ST, ga(40, 2)); step(); idle_all();
                stx_chk("R6", i, ga(40, 0), 1'b1);
            end
        // R7 exception return hits only its own core
        for (int i = 0; i < N; i++) begin
            for (int c = 0; c < N; c++) put(c, C_LDX, ga(50+c, 0));
            step(); idle_all();
            eret[i] = 1'b1; step(); idle_all();
            for (int c = 0; c < N; c++) put(c, C_STX, ga(50+c, 0));
            step();
            for (int c = 0; c < N; c++) chk("R7", c, 1, c == i, c != i);
            idle_all();
        end
        // R8 clear
        for (int c = 0; c < N; c++) begin
            ldx(c, ga(60, 0));
            put(c, C_CLR, ga(60, 0)); step(); chk("R8", c, 0, 0, 0); idle_all();
            stx_chk("R8", c, ga(60, 0), 1'b0);
        end
        // R9 same-cycle contention, lowest index wins
        for (int k = 0; k < N; k++) begin
            for (int c = 0; c < N; c++) put(c, C_LDX, ga(70, 4*c));
            step(); idle_all();
            for (int c = k; c < N; c++) put(c, C_STX, ga(70, c));
            step();
            for (int c = k; c < N; c++) chk("R9", c, 1, c != k, c == k);
            idle_all();
            for (int c = 0; c < k; c++) stx_chk("R9", c, ga(70, 0), 1'b0);
        end
        // R10 pulse length and no spurious status
        ldx(0, ga(80, 0));
        put(0, C_STX, ga(80, 0)); step(); chk("R10", 0, 1, 0, 1); idle_all();
        step();
        for (int c = 0; c < N; c++) chk("R10", c, 0, 0, 0);
        // R11 same-cycle precedence
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++) if (i != j) begin
                put(i, C_LDX, ga(90, 0)); put(j, C_ST, ga(90, 1)); step(); idle_all();
                stx_chk("R11", i, ga(90, 0), 1'b1);
                ldx(i, ga(90, 0));
                put(i, C_STX, ga(90, 0)); put(j, C_ST, ga(90, 3)); step();
                chk("R11", i, 1, 1, 0); idle_all();
            end
        for (int c = 0; c < N; c++) begin
            put(c, C_LDX, ga(95, 0)); eret[c] = 1'b1; step(); idle_all();
            stx_chk("R11", c, ga(95, 0), 1'b1);
            ldx(c, ga(95, 0));
            put(c, C_STX, ga(95, 0)); eret[c] = 1'b1; step();
            chk("R11", c, 1, 1, 0); idle_all();
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule